// File: doc/BRIEF.md
# Multichannel Ramp Conversion Counter

This block is the digital half of a multichannel single-slope (Wilkinson) converter. All channels share one analog ramp, and they also share one counter that runs in Gray code. A start command clears the counter and every channel's result. The counter then advances once per clock. Each channel watches its own comparator. When the ramp passes the voltage held for that channel, the comparator goes high. The block synchronises that edge and stores the Gray count current at that moment. Only the first edge in a conversion is kept.

The resolution is chosen when the conversion starts. It is the full counter width, two bits less, or four bits less. With the default 12-bit counter these are 12, 10 and 8 bits. The conversion ends in one of two ways: every channel has captured a value, or the counter reaches the full-scale code of the chosen resolution. At the end, any channel without a capture takes the full-scale code, and a done flag is raised. The stored Gray codes are converted to binary at the outputs, so readout logic sees plain binary results. The ramp and the comparators are outside the block.

Top module: `ramp_conv_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, busy_o, done_o and every hit_o bit are 0, and every channel code reads 0.
- R2: A start_i pulse sampled at clock edge S clears the counter to 0 and begins counting. After edge S, busy_o is 1. After each later edge S+k of the run, the count is k.
- R3: Let a channel's comparator first be sampled high at edge S+d, with d at least 1, after being low. The edge passes through two synchroniser flops and one edge-detect flop. The channel then stores count d+1 and sets its hit_o bit, provided that d+1 is not above full scale.
- R4: Each channel captures at most once per conversion. Later falling and rising edges of its comparator in the same conversion leave its code and hit_o unchanged.
- R5: A channel that has not captured when the conversion ends reports the full-scale code 2^B-1 of the selected resolution B, with its hit_o bit at 0.
- R6: res_sel_i is sampled only at the start edge. Value 0 selects B = CNT_W-4, value 1 selects CNT_W-2, and values 2 and 3 select CNT_W. Changing res_sel_i during a run has no effect.
- R7: When the count equals full scale before edge E, busy_o falls and done_o rises at edge E. After a start at edge S this is edge S+2^B.
- R8: When every channel has captured, done_o rises on the edge after the last capture, even if the counter is not at full scale.
- R9: done_o stays high until the next start, which clears done_o and all hit_o bits. A start during a run restarts the conversion from a clean state.
- R10: The counter changes by at most one bit per clock. Channels store Gray codes. code_o gives each channel's result in binary: channel i occupies bits [i*CNT_W +: CNT_W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Conversion clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a conversion (also restarts one in progress) |
| res_sel_i | input | 2 | Resolution select, sampled at start |
| cmp_i | input | N_CH | Per-channel ramp comparator outputs, asynchronous |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | Conversion finished, results valid |
| hit_o | output | N_CH | Channel captured on its comparator edge |
| code_o | output | N_CH*CNT_W | Binary result per channel |

## Verification
The bench uses a narrow counter so that every resolution can be swept end to end. For each resolution, the comparator edge of one channel is moved across every count from the first cycle to past full scale. In one pattern, one channel never fires. This forces the full-scale end and shows that a channel without an edge saturates. In the other pattern, all channels fire early. This separates the early all-captured finish from the full-scale finish and shows the one-cycle latency of each. Further runs bounce a comparator after its capture, change the resolution select in the middle of a run, and restart a conversion in progress. These runs show that only the first edge counts, that the resolution is fixed at start, and that a start clears the results.

// File: rtl/ramp_conv_pkg.sv
package ramp_conv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } conv_state_e;

  localparam logic [1:0] RES_LOW = 2'd0;
  localparam logic [1:0] RES_MID = 2'd1;
endpackage

// File: rtl/gray_to_bin.sv
module gray_to_bin #(
  parameter int W = 12
) (
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bin_o[i] = ^(gray_i >> i);
  end
endmodule

// File: rtl/ramp_gray_counter.sv
module ramp_gray_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] fs_i,
  output logic [CNT_W-1:0] gray_o,
  output logic             full_o
);
  logic [CNT_W-1:0] gray_q;
  logic [CNT_W-1:0] bin;
  logic [CNT_W-1:0] bin_nxt;

  gray_to_bin #(.W(CNT_W)) u_g2b (
    .gray_i (gray_q),
    .bin_o  (bin)
  );

  assign bin_nxt = bin + 1'b1;
  assign full_o  = (bin == fs_i);
  assign gray_o  = gray_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               gray_q <= '0;
    else if (clr_i)            gray_q <= '0;
    else if (en_i && !full_o)  gray_q <= bin_nxt ^ (bin_nxt >> 1);
  end

  // R10
  gray_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ($countones(gray_q ^ $past(gray_q)) <= 1));

  // R2
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !clr_i |-> (bin <= fs_i));
endmodule

// File: rtl/ramp_conv_seq.sv
module ramp_conv_seq
  import ramp_conv_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       res_sel_i,
  input  logic             full_i,
  input  logic             all_hit_i,
  output logic             run_o,
  output logic             done_o,
  output logic             end_o,
  output logic [CNT_W-1:0] fs_o
);
  localparam logic [CNT_W-1:0] FS_HI  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] FS_MID = FS_HI >> 2;
  localparam logic [CNT_W-1:0] FS_LO  = FS_HI >> 4;

  conv_state_e state_q, state_d;
  logic [1:0]  res_q;

  always_comb begin
    case (res_q)
      RES_LOW: fs_o = FS_LO;
      RES_MID: fs_o = FS_MID;
      default: fs_o = FS_HI;
    endcase
  end

  assign run_o  = (state_q == ST_RUN);
  assign done_o = (state_q == ST_DONE);
  assign end_o  = run_o && !start_i && (full_i || all_hit_i);

  always_comb begin
    state_d = state_q;
    if (start_i)    state_d = ST_RUN;
    else if (end_o) state_d = ST_DONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      res_q   <= RES_LOW;
    end else begin
      state_q <= state_d;
      if (start_i) res_q <= res_sel_i;
    end
  end

  // R7
  full_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o && full_i && !start_i |=> done_o && !run_o);

  // R9
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o);

  // R2
  start_runs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> run_o && !done_o);

  // R6
  res_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(fs_o));
endmodule

// File: rtl/ramp_chan_capture.sv
module ramp_chan_capture #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmp_i,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic             end_i,
  input  logic [CNT_W-1:0] cnt_gray_i,
  output logic             hit_o,
  output logic [CNT_W-1:0] code_gray_o
);
  logic             sync1_q, sync2_q, prev_q;
  logic             hit_q;
  logic [CNT_W-1:0] code_q;
  logic             rise;
  logic             cap;

  assign rise = sync2_q && !prev_q;
  assign cap  = run_i && !hit_q && (rise || end_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      sync1_q <= cmp_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q  <= 1'b0;
      code_q <= '0;
    end else if (clr_i) begin
      hit_q  <= 1'b0;
      code_q <= '0;
    end else if (cap) begin
      hit_q  <= rise;
      code_q <= cnt_gray_i;
    end
  end

  assign hit_o       = hit_q;
  assign code_gray_o = code_q;

  // R4
  capture_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_q && !clr_i |=> $stable(code_q) && hit_q);

  // R3
  edge_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && rise && !hit_q && !clr_i |=> hit_q);
endmodule

// File: rtl/ramp_conv_ctrl.sv
module ramp_conv_ctrl #(
  parameter int N_CH  = 36,
  parameter int CNT_W = 12
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [1:0]            res_sel_i,
  input  logic [N_CH-1:0]       cmp_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic [N_CH-1:0]       hit_o,
  output logic [N_CH*CNT_W-1:0] code_o
);
  logic [CNT_W-1:0] cnt_gray;
  logic [CNT_W-1:0] fs;
  logic             cnt_full;
  logic             run, fin, all_hit;
  logic [N_CH-1:0]  hit;

  assign all_hit = &hit;

  ramp_conv_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .res_sel_i (res_sel_i),
    .full_i    (cnt_full),
    .all_hit_i (all_hit),
    .run_o     (run),
    .done_o    (done_o),
    .end_o     (fin),
    .fs_o      (fs)
  );

  ramp_gray_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_i),
    .en_i   (run),
    .fs_i   (fs),
    .gray_o (cnt_gray),
    .full_o (cnt_full)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [CNT_W-1:0] code_gray;

    ramp_chan_capture #(.CNT_W(CNT_W)) u_cap (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cmp_i       (cmp_i[c]),
      .clr_i       (start_i),
      .run_i       (run),
      .end_i       (fin),
      .cnt_gray_i  (cnt_gray),
      .hit_o       (hit[c]),
      .code_gray_o (code_gray)
    );

    gray_to_bin #(.W(CNT_W)) u_out (
      .gray_i (code_gray),
      .bin_o  (code_o[c*CNT_W +: CNT_W])
    );
  end

  assign busy_o = run;
  assign hit_o  = hit;

  // R8
  all_hit_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && all_hit && !start_i |=> done_o);

  // R9
  start_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (hit_o == '0) && !done_o);
endmodule

// File: tb/ramp_conv_ctrl_bench.sv
module ramp_conv_ctrl_bench;
  localparam int NC = 4;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    res_sel = 2'd0;
  logic [NC-1:0] cmp = '0;
  logic          busy, done;
  logic [NC-1:0] hit;
  logic [NC*CW-1:0] code;

  int checks = 0;
  int errors = 0;
  int dly [NC];
  bit bounce = 1'b0;

  always #5 clk = ~clk;

  ramp_conv_ctrl #(.N_CH(NC), .CNT_W(CW)) u_ramp_conv_ctrl (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .start_i   (start),
    .res_sel_i (res_sel),
    .cmp_i     (cmp),
    .busy_o    (busy),
    .done_o    (done),
    .hit_o     (hit),
    .code_o    (code)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int full_scale(input int r);
    int b;
    b = (r == 0) ? CW - 4 : (r == 1) ? CW - 2 : CW;
    return (1 << b) - 1;
  endfunction

  // Runs one conversion with comparator rise iterations in dly (0 = never).
  task automatic run_conv(input int r, input int r_after);
    int fs, done_k, exp_done, maxd;
    bit all_fire;
    fs = full_scale(r);
    @(negedge clk);
    start = 1'b1;
    res_sel = r[1:0];
    @(negedge clk);
    start = 1'b0;
    res_sel = r_after[1:0];   // R6: must be ignored
    chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    chk(done == 1'b0 && hit == '0, "R9 cleared by start", int'({done, hit}), 0);
    all_fire = 1'b1;
    maxd = 0;
    for (int c = 0; c < NC; c++) begin
      if (dly[c] < 1 || dly[c] > fs - 1) all_fire = 1'b0;
      if (dly[c] > maxd) maxd = dly[c];
    end
    exp_done = (all_fire && maxd + 4 < fs + 2) ? maxd + 4 : fs + 2;
    done_k = 0;
    for (int k = 1; k < fs + 16; k++) begin
      if (k > 1) @(negedge clk);
      if (done) begin
        done_k = k;
        break;
      end
      for (int c = 0; c < NC; c++) begin
        if (dly[c] == k) cmp[c] = 1'b1;
      end
      if (bounce && k == dly[0] + 3) cmp[0] = 1'b0;
      if (bounce && k == dly[0] + 6) cmp[0] = 1'b1;
    end
    if (all_fire && maxd + 4 < fs + 2)
      chk(done_k == exp_done, "R8 early done cycle", done_k, exp_done);
    else
      chk(done_k == exp_done, "R7 full-scale done cycle", done_k, exp_done);
    chk(busy == 1'b0, "R7 busy low at done", int'(busy), 0);
    for (int c = 0; c < NC; c++) begin
      int ec, act;
      bit eh;
      eh = (dly[c] >= 1 && dly[c] <= fs - 1);
      ec = eh ? dly[c] + 1 : fs;
      act = int'(code[c*CW +: CW]);
      if (eh) chk(act == ec, "R3 R10 captured code", act, ec);
      else    chk(act == ec, "R5 saturated code", act, ec);
      chk(hit[c] == eh, "R3 R5 hit flag", int'(hit[c]), int'(eh));
    end
    repeat (2) @(negedge clk);
    chk(done == 1'b1, "R9 done held", int'(done), 1);
    cmp = '0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(busy == 0 && done == 0 && hit == 0 && code == 0, "R1 reset state",
        int'({busy, done, hit}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && done == 0 && hit == 0 && code == 0, "R1 after release",
        int'({busy, done, hit}), 0);

    for (int r = 0; r < 4; r++) begin
      int fs;
      fs = full_scale(r);
      for (int d = 1; d <= fs + 1; d++) begin
        dly[0] = d; dly[1] = 0; dly[2] = 1;
        dly[3] = (fs - d >= 1) ? fs - d : 0;
        run_conv(r, (r + 1) % 4);
        dly[0] = d; dly[1] = (d % 5) + 1; dly[2] = 1;
        dly[3] = (d > 1) ? d - 1 : 1;
        run_conv(r, (r + 2) % 4);
      end
    end

    // R4: comparator bounces after capture
    bounce = 1'b1;
    dly[0] = 2; dly[1] = 0; dly[2] = 5; dly[3] = 9;
    run_conv(1, 0);
    bounce = 1'b0;

    // R9: restart during a run
    @(negedge clk);
    start = 1'b1;
    res_sel = 2'd2;
    @(negedge clk);
    start = 1'b0;
    cmp[0] = 1'b1;
    repeat (6) @(negedge clk);
    chk(hit[0] == 1'b1 && busy == 1'b1, "R9 mid-run capture", int'({hit[0], busy}), 3);
    cmp = '0;
    dly[0] = 1; dly[1] = 4; dly[2] = 0; dly[3] = 7;
    run_conv(1, 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule